// File: doc/BRIEF.md
# Transmit Frame Buffer with Replay Control

This block is the transmit-side byte store between a host writer and a MAC reader. The host pushes frame bytes and marks the final byte of each frame. The MAC is told when the oldest resident frame may begin. It then pulls bytes one at a time and closes each attempt with one of three outcomes: success, collision or underrun. The store keeps the first byte position of every resident frame, so a collision early in the frame or an underrun can replay that frame from its first byte without the host writing it again.

Up to two frames may be resident at a time, so a second frame can wait ready behind the one on the wire. Transmission normally begins once a selectable number of bytes of the head frame is present. After an underrun the block stops honouring that early start and waits for whole frames. The block gives up on a frame once a bounded number of underrun retries has failed.

Top module: `tx_retry_fifo`

## Requirements
- R1: The store holds 2048 bytes. For every attempt, bytes leave on `rd_data_o` in the order they were written for that frame, including after the write pointer wraps.
- R2: At most two frames are resident. While two are resident, `wr_ready_o` is low for the first byte of a new frame. It rises again once one of them is released.
- R3: The first byte of a frame is accepted only when at least MAX_FRAME (default 1518) bytes are free. Later bytes of the same frame need only one free byte.
- R4: `frame_avail_o` is high when the head frame is complete, or when the bytes already written for it reach the threshold set by `thr_sel_i`: code 0 selects 64 bytes, code 1 selects 128, code 2 selects 256 and code 3 selects 512.
- R5: A collision reported after at most 64 bytes of the attempt have been popped ends the attempt with no status pulse. The frame stays resident, and the next start replays it from byte 0.
- R6: A collision reported after more than 64 popped bytes drops the frame and frees its space. `late_col_o` pulses for one cycle, and the next resident frame becomes the head.
- R7: An underrun sets `force_full_o` and ends the attempt. The frame is replayed from byte 0. While `force_full_o` is high, `frame_avail_o` rises only for a complete frame.
- R8: The underrun that follows three failed retries drops the frame and pulses `abandon_o` for one cycle. `force_full_o` stays high for the next frame. A successful completion clears both `force_full_o` and the retry count.
- R9: `rd_last_o` is high while the final byte of a complete frame is presented. `tx_done_i` releases the frame's space.
- R10: After reset, `wr_ready_o` is high and `frame_avail_o`, `force_full_o`, `abandon_o` and `late_col_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host byte valid |
| wr_data_i | input | 8 | Host byte |
| wr_last_i | input | 1 | Marks the final byte of a frame |
| wr_ready_o | output | 1 | Host byte accepted this cycle when valid |
| thr_sel_i | input | 2 | Early-start threshold code (0:64, 1:128, 2:256, 3:512 bytes) |
| frame_avail_o | output | 1 | Head frame may start |
| tx_start_i | input | 1 | MAC begins an attempt on the head frame |
| rd_pop_i | input | 1 | MAC consumes the presented byte |
| rd_data_o | output | 8 | Presented byte |
| rd_valid_o | output | 1 | A byte is present for the current attempt |
| rd_last_o | output | 1 | Presented byte is the final byte of the frame |
| tx_col_i | input | 1 | Collision ends the attempt |
| tx_urun_i | input | 1 | Underrun ends the attempt |
| tx_done_i | input | 1 | Attempt completed successfully |
| force_full_o | output | 1 | Early start suppressed; whole frames required |
| abandon_o | output | 1 | One-cycle pulse: frame dropped after retries ran out |
| late_col_o | output | 1 | One-cycle pulse: frame dropped on late collision |

## Verification
The assertions assume that the MAC raises at most one of `tx_done_i`, `tx_col_i` and `tx_urun_i` in a cycle, and only during an attempt. They also assume that `tx_start_i` is acted on only while `frame_avail_o` is high, and that `tx_done_i` follows only a fully popped, complete frame. The stimulus pulses each outcome for exactly one cycle after the relevant pops. It raises `rd_pop_i` only for bytes known to be present and starts an attempt only after `frame_avail_o` has been checked. The host side holds `wr_valid_i` until `wr_ready_o` accepts each byte.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {THR_64 = 2'd0, THR_128 = 2'd1, THR_256 = 2'd2, THR_512 = 2'd3} drain_sel_e;

  function automatic int unsigned drain_bytes(drain_sel_e s);
    return 32'd64 << s;
  endfunction
endpackage

// File: rtl/tx_byte_store.sv
module tx_byte_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [2**AW];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_frame_table.sv
module tx_frame_table #(
  parameter int PW    = 12,
  parameter int SLOTS = 2,
  localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [PW-1:0] push_ptr_i,
  input  logic          close_i,
  input  logic [PW-1:0] close_ptr_i,
  input  logic          pop_i,
  output logic [CW-1:0] cnt_o,
  output logic [PW-1:0] head_start_o,
  output logic [PW-1:0] head_end_o,
  output logic          head_done_o
);
  logic [PW-1:0]    start_q [SLOTS];
  logic [PW-1:0]    end_q   [SLOTS];
  logic [SLOTS-1:0] done_q;
  logic [IW-1:0]    hd_q, tl_q, close_slot;
  logic [CW-1:0]    cnt_q;

  // a one-byte frame opens and closes in the same cycle
  assign close_slot = push_i ? tl_q : IW'(tl_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_q   <= '0;
      tl_q   <= '0;
      cnt_q  <= '0;
      done_q <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
      end
    end else begin
      if (push_i) begin
        start_q[tl_q] <= push_ptr_i;
        done_q[tl_q]  <= 1'b0;
        tl_q          <= IW'(tl_q + 1'b1);
      end
      if (close_i) begin
        end_q[close_slot]  <= close_ptr_i;
        done_q[close_slot] <= 1'b1;
      end
      if (pop_i) hd_q <= IW'(hd_q + 1'b1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign cnt_o        = cnt_q;
  assign head_start_o = start_q[hd_q];
  assign head_end_o   = end_q[hd_q];
  assign head_done_o  = done_q[hd_q];

  assert_slot_limit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(SLOTS));
endmodule

// File: rtl/tx_retry_fifo.sv
module tx_retry_fifo
  import txf_pkg::*;
#(
  parameter int AW        = 11,
  parameter int MAX_FRAME = 1518,
  parameter int COL_WIN   = 64,
  parameter int RETRIES   = 3,
  parameter int SLOTS     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       wr_last_i,
  output logic       wr_ready_o,
  input  logic [1:0] thr_sel_i,
  output logic       frame_avail_o,
  input  logic       tx_start_i,
  input  logic       rd_pop_i,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o,
  output logic       rd_last_o,
  input  logic       tx_col_i,
  input  logic       tx_urun_i,
  input  logic       tx_done_i,
  output logic       force_full_o,
  output logic       abandon_o,
  output logic       late_col_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(SLOTS + 1);
  localparam int RW    = $clog2(RETRIES + 1);

  logic [PW-1:0] wr_ptr_q, free_ptr_q, rd_ptr_q, sent_q;
  logic          open_q, busy_q, dead_q, ff_q, abandon_q, late_q;
  logic [RW-1:0] urun_cnt_q;

  logic [PW-1:0] occ, free_b, head_len, rd_lim, thr_b;
  logic [PW-1:0] head_start, head_end;
  logic          head_done;
  logic [CW-1:0] cnt;
  logic          wr_fire, push, close, pop_ok, start_ok;
  logic          done_ev, col_ev, ur_ev, late, give_up, discard, pop_desc;

  assign occ     = wr_ptr_q - free_ptr_q;
  assign free_b  = PW'(DEPTH) - occ;
  assign wr_ready_o = open_q ? (free_b != '0)
                             : (cnt < CW'(SLOTS) && free_b >= PW'(MAX_FRAME));
  assign wr_fire = wr_valid_i && wr_ready_o;
  assign push    = wr_fire && !open_q;
  assign close   = wr_fire && wr_last_i;

  assign head_len = head_done ? (head_end - head_start) : (wr_ptr_q - head_start);
  assign thr_b    = PW'(drain_bytes(drain_sel_e'(thr_sel_i)));
  assign frame_avail_o = (cnt != '0) && !busy_q && !dead_q &&
                         (head_done || (!ff_q && head_len >= thr_b));

  assign rd_lim     = head_done ? head_end : wr_ptr_q;
  assign rd_valid_o = busy_q && (rd_ptr_q != rd_lim);
  assign rd_last_o  = busy_q && head_done && (PW'(rd_ptr_q + 1'b1) == head_end);

  assign start_ok = tx_start_i && frame_avail_o;
  assign pop_ok   = busy_q && rd_pop_i && rd_valid_o;
  assign done_ev  = busy_q && tx_done_i;
  assign col_ev   = busy_q && !tx_done_i && tx_col_i;
  assign ur_ev    = busy_q && !tx_done_i && !tx_col_i && tx_urun_i;
  assign late     = col_ev && (sent_q > PW'(COL_WIN));
  assign give_up  = ur_ev && (urun_cnt_q == RW'(RETRIES));
  assign discard  = late || give_up;
  // a dropped frame still being written is freed once its last byte lands
  assign pop_desc = done_ev || (discard && head_done) || (dead_q && head_done);

  tx_byte_store #(.AW(AW), .DW(8)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .waddr_i (wr_ptr_q[AW-1:0]),
    .wdata_i (wr_data_i),
    .raddr_i (rd_ptr_q[AW-1:0]),
    .rdata_o (rd_data_o)
  );

  tx_frame_table #(.PW(PW), .SLOTS(SLOTS)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_ptr_i   (wr_ptr_q),
    .close_i      (close),
    .close_ptr_i  (PW'(wr_ptr_q + 1'b1)),
    .pop_i        (pop_desc),
    .cnt_o        (cnt),
    .head_start_o (head_start),
    .head_end_o   (head_end),
    .head_done_o  (head_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      free_ptr_q <= '0;
      rd_ptr_q   <= '0;
      sent_q     <= '0;
      open_q     <= 1'b0;
      busy_q     <= 1'b0;
      dead_q     <= 1'b0;
      ff_q       <= 1'b0;
      urun_cnt_q <= '0;
      abandon_q  <= 1'b0;
      late_q     <= 1'b0;
    end else begin
      if (wr_fire) begin
        wr_ptr_q <= PW'(wr_ptr_q + 1'b1);
        open_q   <= !wr_last_i;
      end
      if (pop_desc) free_ptr_q <= head_end;

      if (start_ok) begin
        busy_q   <= 1'b1;
        rd_ptr_q <= head_start;
        sent_q   <= '0;
      end else if (done_ev || col_ev || ur_ev) begin
        busy_q   <= 1'b0;
        rd_ptr_q <= head_start;
      end else if (pop_ok) begin
        rd_ptr_q <= PW'(rd_ptr_q + 1'b1);
        sent_q   <= PW'(sent_q + 1'b1);
      end

      if (discard && !head_done) dead_q <= 1'b1;
      else if (pop_desc)         dead_q <= 1'b0;

      if (ur_ev)        ff_q <= 1'b1;
      else if (done_ev) ff_q <= 1'b0;

      if (ur_ev)        urun_cnt_q <= give_up ? '0 : RW'(urun_cnt_q + 1'b1);
      else if (done_ev) urun_cnt_q <= '0;

      abandon_q <= give_up;
      late_q    <= late;
    end
  end

  assign force_full_o = ff_q;
  assign abandon_o    = abandon_q;
  assign late_col_o   = late_q;

  assert_occ_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= PW'(DEPTH));
  assert_replay_origin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> rd_ptr_q == head_start);
  assert_late_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_col_o |-> !busy_q);
  assert_full_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_full_o && frame_avail_o) |-> head_done);
  assert_giveup_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abandon_o |-> force_full_o);
endmodule

// File: tb/tx_retry_fifo_test.sv
module tx_retry_fifo_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_valid_i, wr_last_i, wr_ready_o;
  logic [7:0] wr_data_i;
  logic [1:0] thr_sel_i;
  logic       frame_avail_o, tx_start_i, rd_pop_i, rd_valid_o, rd_last_o;
  logic [7:0] rd_data_o;
  logic       tx_col_i, tx_urun_i, tx_done_i;
  logic       force_full_o, abandon_o, late_col_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] exp_b;

  tx_retry_fifo uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] fb(int id, int i);
    return 8'((id * 37 + i) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // monitor: compare each consumed byte against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rd_pop_i && rd_valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected byte", rd_data_o, -1);
      else begin
        exp_b = exp_q.pop_front();
        check(rd_data_o == exp_b, "R1 byte order", rd_data_o, exp_b);
      end
    end
  end

  task automatic wr_bytes(input int id, input int from, input int to, input bit fin);
    for (int i = from; i < to; i++) begin
      wr_valid_i = 1'b1;
      wr_data_i  = fb(id, i);
      wr_last_i  = fin && (i == to - 1);
      while (!wr_ready_o) tick();
      tick();
    end
    wr_valid_i = 1'b0;
    wr_last_i  = 1'b0;
  endtask

  task automatic start_tx();
    tx_start_i = 1'b1;
    tick();
    tx_start_i = 1'b0;
  endtask

  task automatic pop_n(input int id, input int from, input int n, input bit last_chk);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(fb(id, from + k));
      rd_pop_i = 1'b1;
      if (last_chk && k == n - 1) check(rd_last_o == 1'b1, "R9 last marker", rd_last_o, 1);
      if (last_chk && k == n - 2) check(rd_last_o == 1'b0, "R9 not last", rd_last_o, 0);
      tick();
    end
    rd_pop_i = 1'b0;
  endtask

  task automatic ev(input int which);
    case (which)
      0: tx_done_i = 1'b1;
      1: tx_col_i  = 1'b1;
      default: tx_urun_i = 1'b1;
    endcase
    tick();
    tx_done_i = 1'b0;
    tx_col_i  = 1'b0;
    tx_urun_i = 1'b0;
  endtask

  task automatic send(input int id, input int len);
    check(frame_avail_o == 1'b1, "R4 avail before send", frame_avail_o, 1);
    start_tx();
    pop_n(id, 0, len, 1'b1);
    ev(0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R10 actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    wr_valid_i = 1'b0; wr_last_i = 1'b0; wr_data_i = '0; thr_sel_i = 2'd0;
    tx_start_i = 1'b0; rd_pop_i = 1'b0; tx_col_i = 1'b0; tx_urun_i = 1'b0; tx_done_i = 1'b0;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    check(wr_ready_o == 1'b1, "R10 ready", wr_ready_o, 1);
    check(frame_avail_o == 1'b0, "R10 avail", frame_avail_o, 0);
    check(force_full_o == 1'b0, "R10 force_full", force_full_o, 0);
    check(abandon_o == 1'b0 && late_col_o == 1'b0, "R10 pulses", abandon_o, 0);

    // R4: threshold code 0 = 64 bytes
    wr_bytes(1, 0, 63, 1'b0);
    check(frame_avail_o == 1'b0, "R4 below 64", frame_avail_o, 0);
    wr_bytes(1, 63, 64, 1'b0);
    check(frame_avail_o == 1'b1, "R4 at 64", frame_avail_o, 1);

    // R7: underrun on an incomplete frame
    start_tx();
    pop_n(1, 0, 64, 1'b0);
    check(rd_valid_o == 1'b0, "R7 starved", rd_valid_o, 0);
    ev(2);
    check(force_full_o == 1'b1, "R7 force_full set", force_full_o, 1);
    check(frame_avail_o == 1'b0, "R7 waits for whole frame", frame_avail_o, 0);
    wr_bytes(1, 64, 100, 1'b1);
    check(frame_avail_o == 1'b1, "R7 whole frame ready", frame_avail_o, 1);
    send(1, 100);
    check(force_full_o == 1'b0, "R8 success clears", force_full_o, 0);

    // R5: early collision at exactly 64 bytes
    wr_bytes(2, 0, 80, 1'b1);
    start_tx();
    pop_n(2, 0, 64, 1'b0);
    ev(1);
    check(late_col_o == 1'b0, "R5 no late pulse", late_col_o, 0);
    check(frame_avail_o == 1'b1, "R5 replay ready", frame_avail_o, 1);
    send(2, 80);

    // R2 and R6: two frames resident, late collision drops the head
    wr_bytes(3, 0, 100, 1'b1);
    wr_bytes(4, 0, 40, 1'b1);
    check(wr_ready_o == 1'b0, "R2 two frames block", wr_ready_o, 0);
    start_tx();
    pop_n(3, 0, 65, 1'b0);
    ev(1);
    check(late_col_o == 1'b1, "R6 late pulse", late_col_o, 1);
    check(wr_ready_o == 1'b1, "R2 slot freed", wr_ready_o, 1);
    tick();
    check(late_col_o == 1'b0, "R6 pulse width", late_col_o, 0);
    send(4, 40);

    // R8: retries exhausted
    wr_bytes(5, 0, 30, 1'b1);
    for (int r = 0; r < 3; r++) begin
      start_tx();
      pop_n(5, 0, 10, 1'b0);
      ev(2);
      check(abandon_o == 1'b0, "R8 still retrying", abandon_o, 0);
    end
    check(force_full_o == 1'b1 && frame_avail_o == 1'b1, "R7 complete frame retried", frame_avail_o, 1);
    start_tx();
    pop_n(5, 0, 10, 1'b0);
    ev(2);
    check(abandon_o == 1'b1, "R8 abandon pulse", abandon_o, 1);
    check(force_full_o == 1'b1, "R8 force_full kept", force_full_o, 1);
    check(frame_avail_o == 1'b0, "R8 frame dropped", frame_avail_o, 0);
    tick();
    check(abandon_o == 1'b0, "R8 pulse width", abandon_o, 0);
    wr_bytes(6, 0, 70, 1'b0);
    check(frame_avail_o == 1'b0, "R8 next frame forced full", frame_avail_o, 0);
    wr_bytes(6, 70, 100, 1'b1);
    send(6, 100);
    check(force_full_o == 1'b0, "R8 cleared after success", force_full_o, 0);

    // R4 code 3 = 512 bytes, R3 room rule
    thr_sel_i = 2'd3;
    wr_bytes(7, 0, 511, 1'b0);
    check(frame_avail_o == 1'b0, "R4 below 512", frame_avail_o, 0);
    wr_bytes(7, 511, 512, 1'b0);
    check(frame_avail_o == 1'b1, "R4 at 512", frame_avail_o, 1);
    wr_bytes(7, 512, 600, 1'b1);
    check(wr_ready_o == 1'b0, "R3 room below max frame", wr_ready_o, 0);
    send(7, 600);
    check(wr_ready_o == 1'b1, "R3 room restored", wr_ready_o, 1);

    // R1: wrap the pointers
    wr_bytes(8, 0, 1000, 1'b1);
    send(8, 1000);
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule